// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Word Converter

This block takes a serial NRZ stream, one bit per clock edge, and assembles it into parallel words of `WORD_W` bits (four by default). Two serial inputs exist: the normal link input and a loopback input. A select pin picks which of them is sampled. The loopback input pairs with a companion serializer, so a link can be tested without the medium.

Alongside the word, the block drives a word clock at one quarter of the bit rate. That clock rises in the same cycle a fresh word appears, so downstream logic can capture each word on its rising edge. The block also drives a clock at one eighth of the bit rate and a pass-through serial output. The pass-through output carries each bit once it has left the last shift stage. Two units built from the same reset can therefore be chained. The first unit's pass-through output feeds the second unit's link input, and together they form a 1:8 demultiplexer. The second unit's word holds the earlier four bits of each group of eight (outputs 0 to 3). The first unit's word holds the later four bits (outputs 4 to 7).

In a chain, the clock-to-output delay of the pass-through path plus the input setup of the next unit must fit within one bit period.

Top module: `bitdes_top`

## Requirements
- R1: While `rst` is high at a clock edge, the shift stages, the word counter, `word_o`, `div4_o`, `div8_o` and `chain_o` are all cleared to 0 after that edge.
- R2: At each edge the block samples `line_i` when `loop_sel_i` is 0 and `loop_i` when `loop_sel_i` is 1. The input that is not selected has no effect on any output.
- R3: The first bit sampled after reset lands in `word_o[0]`. More generally, the bit sampled k edges after a word boundary lands in `word_o[k]` (least significant bit first).
- R4: Counting edges from 1 after reset release, `word_o` changes only after edges 4, 8, 12, … and otherwise holds its value. Before edge 4 it stays at 0.
- R5: `div4_o` is 0 until edge 4. From then on it is 1 after edges where the count mod 4 is 0 or 1, and 0 after the others. It therefore rises in the same cycle a new word appears.
- R6: `div8_o` is 0 until edge 4 and toggles on every rising transition of `div4_o`, giving a period of 8 bits.
- R7: The bit sampled at edge n is driven on `chain_o` after edge n+3 and up to edge n+4. A chained unit therefore samples it exactly four edges after the first unit did. Before edge 4, `chain_o` is 0.
- R8: Changing `loop_sel_i` in the middle of a word switches the sampled input at the next edge and does not shift the word boundaries.
- R9: With two units chained from a common reset, the second unit's word after edge 4m (m ≥ 2) holds the bits sampled by the first unit at edges 4m−7 to 4m−4, the earliest in bit 0. After edge 4, the second unit's word is 0.
- R10: A reset asserted in the middle of a word discards the partial word, and framing restarts from edge 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial input from the link |
| loop_i | input | 1 | Serial input for loopback test |
| loop_sel_i | input | 1 | 1 selects `loop_i`, 0 selects `line_i` |
| word_o | output | WORD_W | Parallel word, first-received bit in bit 0 |
| div4_o | output | 1 | Word clock, bit rate divided by four |
| div8_o | output | 1 | Bit rate divided by eight |
| chain_o | output | 1 | Serial pass-through from the last shift stage |

## Verification
A bit sampled at edge n reaches `word_o` at the next multiple-of-four edge, together with the rise of `div4_o`. It shows on `chain_o` three edges later and reaches a chained unit's word four edges after the first unit's word boundary. The bench numbers edges from reset release and drives inputs on the falling edge before each sampling edge. It compares every output on the falling edge after each rising edge against values it derives from the recorded stream at those offsets. The words themselves pass through a queue filled by the driver at each fourth bit and drained by a monitor when it sees `div4_o` go high.

// File: rtl/bitdes_pkg.sv
package bitdes_pkg;

    localparam int unsigned WORD_W_DEF = 4;

    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_LOOP = 1'b1
    } src_e;

    typedef struct packed {
        logic div4;
        logic div8;
    } divclk_t;

    function automatic logic pick_bit(src_e src, logic line_b, logic loop_b);
        return (src == SRC_LOOP) ? loop_b : line_b;
    endfunction

endpackage

// File: rtl/bitdes_inmux.sv
module bitdes_inmux
    import bitdes_pkg::*;
(
    input  logic sel_i,
    input  logic line_i,
    input  logic loop_i,
    output logic bit_o
);

    src_e src;

    always_comb begin
        src   = src_e'(sel_i);
        bit_o = pick_bit(src, line_i, loop_i);
    end

endmodule

// File: rtl/bitdes_shift.sv
module bitdes_shift #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_i,
    output logic [W-1:0] nxt_o,
    output logic         ser_o
);

    localparam int unsigned WMW = $clog2(W + 1);

    logic [W-1:0]   stage_q;
    logic [WMW-1:0] warm_q;

    assign nxt_o = {bit_i, stage_q[W-1:1]};
    assign ser_o = stage_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= nxt_o;
        end
    end

    // Edges since reset, saturating at W; guards the delay check below.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != WMW'(W)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    AST_SER_DELAY: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WMW'(W)) |-> (ser_o == $past(bit_i, W))); // R7

endmodule

// File: rtl/bitdes_frame.sv
module bitdes_frame
    import bitdes_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic    clk,
    input  logic    rst,
    output logic    wrap_o,
    output divclk_t clks_o
);

    localparam int unsigned CW   = (W > 2) ? $clog2(W) : 1;
    localparam int unsigned HALF = W / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    divclk_t       clk_q;

    assign wrap_o  = (cnt_q == CW'(W - 1));
    assign cnt_nxt = wrap_o ? '0 : cnt_q + 1'b1;
    assign clks_o  = clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            clk_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (wrap_o) begin
                clk_q.div4 <= 1'b1;
                clk_q.div8 <= ~clk_q.div8;
            end else if (cnt_nxt == CW'(HALF)) begin
                clk_q.div4 <= 1'b0;
            end
        end
    end

    AST_DIV4_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> clks_o.div4); // R5

    AST_DIV8_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        $rose(clks_o.div4) |-> (clks_o.div8 != $past(clks_o.div8))); // R6

    AST_DIV8_STEADY: assert property (@(posedge clk) disable iff (rst)
        !$rose(clks_o.div4) |-> $stable(clks_o.div8)); // R6

endmodule

// File: rtl/bitdes_top.sv
module bitdes_top
    import bitdes_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              loop_i,
    input  logic              loop_sel_i,
    output logic [WORD_W-1:0] word_o,
    output logic              div4_o,
    output logic              div8_o,
    output logic              chain_o
);

    logic              bit_sel;
    logic [WORD_W-1:0] nxt;
    logic              wrap;
    divclk_t           clks;
    logic [WORD_W-1:0] word_q;

    bitdes_inmux u_mux (
        .sel_i  (loop_sel_i),
        .line_i (line_i),
        .loop_i (loop_i),
        .bit_o  (bit_sel)
    );

    bitdes_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .bit_i (bit_sel),
        .nxt_o (nxt),
        .ser_o (chain_o)
    );

    bitdes_frame #(.W(WORD_W)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .wrap_o (wrap),
        .clks_o (clks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wrap) begin
            word_q <= nxt;
        end
    end

    assign word_o = word_q;
    assign div4_o = clks.div4;
    assign div8_o = clks.div8;

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(word_o)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (word_o == '0 && !div4_o && !div8_o && !chain_o)); // R1

endmodule

// File: tb/bitdes_top_tb.sv
`timescale 1ns/1ps
module bitdes_top_tb_top;

    localparam int W = 4;
    localparam time CLK_P = 20ns;

    typedef struct {
        logic [W-1:0] word;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b0;
    logic loop_i = 1'b0;
    logic loop_sel = 1'b0;
    logic [W-1:0] word_o, word_hi;
    logic div4_o, div8_o, chain_o;
    logic div4_hi, div8_hi, chain_hi;

    int total = 0;
    int bad = 0;
    int n = 0;
    logic hist [0:511];
    exp_t sbq[$];
    string cur_tag = "R2";
    bit first_word = 1'b1;
    logic d4_last = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bitdes_top #(.WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .line_i(line_i), .loop_i(loop_i),
        .loop_sel_i(loop_sel), .word_o(word_o), .div4_o(div4_o),
        .div8_o(div8_o), .chain_o(chain_o)
    );

    // Second unit of the chain, fed from the first unit's pass-through.
    bitdes_top #(.WORD_W(W)) dut_hi_i (
        .clk(clk), .rst(rst), .line_i(chain_o), .loop_i(1'b0),
        .loop_sel_i(1'b0), .word_o(word_hi), .div4_o(div4_hi),
        .div8_o(div8_hi), .chain_o(chain_hi)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s edge=%0d actual=%h expected=%h", req, n, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word_from(input int start);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[i] = hist[start + i];
        return w;
    endfunction

    // Monitor: pops an expected word on each rise of the word clock.
    always @(negedge clk) begin
        if (rst) begin
            d4_last <= 1'b0;
        end else begin
            if (div4_o && !d4_last) begin
                if (sbq.size() == 0) begin
                    chk("R4", word_o, ~word_o);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.tag, word_o, e.word);
                end
            end
            d4_last <= div4_o;
        end
    end

    task automatic check_edge();
        int m;
        chk("R5", W'(div4_o), W'((n >= 4) && (n % 4 < 2)));
        chk("R6", W'(div8_o), W'((n >= 4) && ((n / 4) % 2 == 1)));
        chk("R7", W'(chain_o), W'((n >= 4) ? hist[n-3] : 1'b0));
        if (n % 4 != 0) begin
            chk("R4", word_o, (n < 4) ? '0 : word_from(4 * (n / 4) - 3));
        end
        m = 4 * (n / 4);
        chk("R9", word_hi, (m < 8) ? '0 : word_from(m - 7));
    endtask

    task automatic step(input logic sel);
        logic a, b;
        a = 1'($urandom % 2);
        b = 1'($urandom % 2);
        line_i   = a;
        loop_i   = b;
        loop_sel = sel;
        hist[n+1] = sel ? b : a;
        if ((n + 1) % 4 == 0) begin
            exp_t e;
            e.word = word_from(n - 2);
            e.tag  = first_word ? "R3" : cur_tag;
            first_word = 1'b0;
            sbq.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        n++;
        check_edge();
    endtask

    task automatic check_reset_state(input string req);
        chk(req, word_o, '0);
        chk(req, W'({div4_o, div8_o, chain_o}), '0);
        chk(req, word_hi, '0);
        chk(req, W'({div4_hi, div8_hi, chain_hi}), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst = 1'b0;
        n = 0;

        cur_tag = "R2";
        for (int k = 0; k < 40; k++) step(1'b0);
        for (int k = 0; k < 40; k++) step(1'b1);

        cur_tag = "R8";
        for (int k = 0; k < 42; k++) step(1'((k / 3) % 2));

        // n is now 122, two bits into a word: reset mid-word.
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R10");
        chk("R10", W'(sbq.size()), '0);
        rst = 1'b0;
        n = 0;
        first_word = 1'b1;
        cur_tag = "R10";
        for (int k = 0; k < 24; k++) step(1'(k % 2));

        repeat (2) @(negedge clk);
        chk("R4", W'(sbq.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule